// File: doc/BRIEF.md
# Two-Entry Decoupling FIFO

This block is a small synchronous queue that sits between a producing pipeline and a consuming unit. Each side sees a plain valid/ready handshake of its own. The producer is told only whether a free slot exists. The consumer is told only whether an item is waiting. Neither ready signal passes through the block combinationally, so the control logic of the two neighbours is split into independent timing paths.

With the default depth of two, the queue keeps one transfer per cycle in steady state. At an occupancy of one, a new item and an outgoing item can cross in the same cycle. A depth parameter of one builds a single-slot variant for comparison. In that variant a slot is either filled or drained in a cycle, never both, so throughput falls to one item every two cycles. The data width is a parameter.

Top module: `dcpl_fifo`

## Requirements
- R1: After reset the queue holds no items, `enq_ready` is 1 and `deq_valid` is 0.
- R2: Items leave in the order they were accepted, each accepted item exactly once, with its data unchanged.
- R3: `enq_ready` is 0 exactly when the queue holds SLOTS items. It comes from registered state only, so it does not change within a cycle when `deq_ready` changes.
- R4: `deq_valid` is 1 exactly when the queue holds at least one item. An item accepted at a clock edge is first offered in the cycle after that edge, never in its own cycle.
- R5: An offer made while `enq_ready` is 0 is ignored, and no item is stored for it.
- R6: With SLOTS=2, at an occupancy of one, an enqueue and a dequeue both complete in the same cycle. With both sides always active from empty, N cycles deliver N-1 items.
- R7: With SLOTS=1, `enq_ready` is 0 whenever the slot is occupied, even while the consumer is ready. With both sides always active from empty, 20 cycles deliver 10 items.
- R8: `deq_data` is driven from storage registers, never from `enq_data`. It holds the head item, unchanged, while `deq_valid` is 1 and `deq_ready` is 0.
- R9: A dequeue frees a slot, so `enq_ready` is 1 in the following cycle. A `deq_ready` asserted while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| enq_valid | input | 1 | Producer offers an item |
| enq_ready | output | 1 | A free slot exists |
| enq_data | input | WIDTH | Item offered by the producer |
| deq_valid | output | 1 | An item is waiting at the head |
| deq_ready | input | 1 | Consumer takes the head item |
| deq_data | output | WIDTH | Head item |

## Verification
The bench builds two copies side by side, one with SLOTS=2 and one with SLOTS=1, both at WIDTH=8, and drives them with the same stimulus. This makes the throughput gap directly visible: 19 items against 10 over 20 fully active cycles. It also lets the bench compare, under the same input stream, the crossing transfer at occupancy one with the forced alternation of the single slot. Rejected offers while full, backpressure holding the head item, a dequeue request while empty, a reset with items inside, and a pseudo-random pattern are all run against both depths.

// File: rtl/dcpl_pkg.sv
package dcpl_pkg;

    // Width of a slot index; at least one bit even for a single slot.
    function automatic int ptr_bits(int slots);
        return (slots > 1) ? $clog2(slots) : 1;
    endfunction

    // Width of an occupancy count covering 0..slots.
    function automatic int cnt_bits(int slots);
        return $clog2(slots + 1);
    endfunction

endpackage

// File: rtl/dcpl_occ.sv
// Occupancy controller: counts items, steps the slot pointers and
// keeps registered full/empty flags that alone drive the handshakes.
module dcpl_occ
    import dcpl_pkg::*;
#(
    parameter  int SLOTS = 2,
    localparam int PW    = ptr_bits(SLOTS),
    localparam int CW    = cnt_bits(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enq_valid,
    input  logic          deq_ready,
    output logic          enq_ready,
    output logic          deq_valid,
    output logic          push,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic          full;
        logic          empty;
    } occ_t;

    occ_t st_d, st_q;
    logic pop;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        if (p == PW'(SLOTS - 1)) begin
            return '0;
        end
        return p + PW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        push = enq_valid && !st_q.full;
        pop  = deq_ready && !st_q.empty;
        if (push) begin
            st_d.wr = bump(st_q.wr);
        end
        if (pop) begin
            st_d.rd = bump(st_q.rd);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        st_d.full  = (st_d.cnt == CW'(SLOTS));
        st_d.empty = (st_d.cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{cnt: '0, wr: '0, rd: '0, full: 1'b0, empty: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign enq_ready = !st_q.full;
    assign deq_valid = !st_q.empty;
    assign wr_ptr    = st_q.wr;
    assign rd_ptr    = st_q.rd;

endmodule

// File: rtl/dcpl_store.sv
// Slot storage: one register per slot, written at the write pointer,
// read out at the read pointer with no path from the write data.
module dcpl_store
    import dcpl_pkg::*;
#(
    parameter  int WIDTH = 8,
    parameter  int SLOTS = 2,
    localparam int PW    = ptr_bits(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [PW-1:0]    wr_ptr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [PW-1:0]    rd_ptr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] slot_d [SLOTS];
    logic [WIDTH-1:0] slot_q [SLOTS];

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            slot_d[i] = (push && (wr_ptr == PW'(i))) ? wr_data : slot_q[i];
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= slot_d[g];
            end
        end
    end

    assign rd_data = slot_q[rd_ptr];

endmodule

// File: rtl/dcpl_fifo.sv
// Decoupling queue top: occupancy controller plus slot storage.
module dcpl_fifo
    import dcpl_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int SLOTS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enq_valid,
    output logic             enq_ready,
    input  logic [WIDTH-1:0] enq_data,
    output logic             deq_valid,
    input  logic             deq_ready,
    output logic [WIDTH-1:0] deq_data
);

    localparam int PW = ptr_bits(SLOTS);

    logic          push;
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    dcpl_occ #(.SLOTS(SLOTS)) u_occ (
        .clk       (clk),
        .rst       (rst),
        .enq_valid (enq_valid),
        .deq_ready (deq_ready),
        .enq_ready (enq_ready),
        .deq_valid (deq_valid),
        .push      (push),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr)
    );

    dcpl_store #(.WIDTH(WIDTH), .SLOTS(SLOTS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .wr_ptr  (wr_ptr),
        .wr_data (enq_data),
        .rd_ptr  (rd_ptr),
        .rd_data (deq_data)
    );

endmodule

// File: rtl/dcpl_fifo_chk.sv
module dcpl_fifo_chk #(
    parameter int WIDTH = 8,
    parameter int SLOTS = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             enq_valid,
    input logic             enq_ready,
    input logic             deq_valid,
    input logic             deq_ready,
    input logic [WIDTH-1:0] deq_data
);

    // R8
    hold_data_chk: assert property (@(posedge clk) disable iff (rst)
        (deq_valid && !deq_ready) |=> (deq_valid && $stable(deq_data)));

    // R4
    stay_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (!deq_valid && !enq_valid) |=> !deq_valid);

    // R4
    fill_shows_chk: assert property (@(posedge clk) disable iff (rst)
        (enq_valid && enq_ready) |=> deq_valid);

    // R3
    stay_full_chk: assert property (@(posedge clk) disable iff (rst)
        (!enq_ready && !deq_ready) |=> !enq_ready);

    // R9
    drain_frees_chk: assert property (@(posedge clk) disable iff (rst)
        (deq_valid && deq_ready) |=> enq_ready);

    // R3
    no_full_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (enq_ready || deq_valid));

    if (SLOTS == 1) begin : g_single
        // R7
        single_block_chk: assert property (@(posedge clk) disable iff (rst)
            (enq_valid && enq_ready) |=> !enq_ready);

        // R7
        single_excl_chk: assert property (@(posedge clk) disable iff (rst)
            !(enq_ready && deq_valid));
    end

endmodule

bind dcpl_fifo dcpl_fifo_chk #(.WIDTH(WIDTH), .SLOTS(SLOTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enq_valid (enq_valid),
    .enq_ready (enq_ready),
    .deq_valid (deq_valid),
    .deq_ready (deq_ready),
    .deq_data  (deq_data)
);

// File: tb/dcpl_fifo_tb.sv
module dcpl_fifo_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enq_valid = 1'b0;
    logic [7:0] enq_data = '0;
    logic       deq_ready = 1'b0;

    logic       enq_ready2, deq_valid2;
    logic [7:0] deq_data2;
    logic       enq_ready1, deq_valid1;
    logic [7:0] deq_data1;

    int n_chk = 0;
    int n_err = 0;
    int deq_cnt2 = 0;
    int deq_cnt1 = 0;
    bit done = 1'b0;

    logic [7:0] exp2[$];
    logic [7:0] exp1[$];

    always #10 clk = ~clk;

    dcpl_fifo #(.WIDTH(8), .SLOTS(2)) u_dut (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_ready(enq_ready2), .enq_data(enq_data),
        .deq_valid(deq_valid2), .deq_ready(deq_ready), .deq_data(deq_data2)
    );

    dcpl_fifo #(.WIDTH(8), .SLOTS(1)) u_dut_one (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_ready(enq_ready1), .enq_data(enq_data),
        .deq_valid(deq_valid1), .deq_ready(deq_ready), .deq_data(deq_data1)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: sets inputs for one cycle, records accepted items.
    task automatic drive(bit ev, logic [7:0] d, bit dr);
        @(negedge clk);
        enq_valid = ev;
        enq_data  = d;
        deq_ready = dr;
        #1;
        if (ev && enq_ready2) exp2.push_back(d);
        if (ev && enq_ready1) exp1.push_back(d);
    endtask

    // Monitors: compare every completed dequeue against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst && deq_valid2 && deq_ready) begin
                deq_cnt2++;
                if (exp2.size() == 0) begin
                    chk(0, "R2", "slots2 unexpected item", int'(deq_data2), -1);
                end else begin
                    logic [7:0] e;
                    e = exp2.pop_front();
                    chk(deq_data2 == e, "R2", "slots2 order", int'(deq_data2), int'(e));
                end
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst && deq_valid1 && deq_ready) begin
                deq_cnt1++;
                if (exp1.size() == 0) begin
                    chk(0, "R2", "slots1 unexpected item", int'(deq_data1), -1);
                end else begin
                    logic [7:0] e;
                    e = exp1.pop_front();
                    chk(deq_data1 == e, "R2", "slots1 order", int'(deq_data1), int'(e));
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        logic [7:0] nxt;
        int c2, c1;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        drive(0, 8'h00, 0);
        // R1 reset state
        chk(enq_ready2 == 1'b1, "R1", "slots2 enq_ready", int'(enq_ready2), 1);
        chk(deq_valid2 == 1'b0, "R1", "slots2 deq_valid", int'(deq_valid2), 0);
        chk(enq_ready1 == 1'b1, "R1", "slots1 enq_ready", int'(enq_ready1), 1);
        chk(deq_valid1 == 1'b0, "R1", "slots1 deq_valid", int'(deq_valid1), 0);

        // Fill with consumer stalled
        drive(1, 8'h11, 0);
        drive(1, 8'h22, 0);
        drive(1, 8'h33, 0);
        // R3 full flags
        chk(enq_ready2 == 1'b0, "R3", "slots2 full", int'(enq_ready2), 0);
        chk(deq_valid2 == 1'b1, "R4", "slots2 valid", int'(deq_valid2), 1);
        chk(enq_ready1 == 1'b0, "R3", "slots1 full", int'(enq_ready1), 0);
        drive(1, 8'h44, 0);
        // R8 head held, not following enq_data
        chk(deq_data2 == 8'h11, "R8", "slots2 head", int'(deq_data2), 'h11);
        chk(deq_data1 == 8'h11, "R8", "slots1 head", int'(deq_data1), 'h11);

        // R3 ready independent of deq_ready within the cycle
        drive(0, 8'h00, 1);
        chk(enq_ready2 == 1'b0, "R3", "slots2 ready with deq_ready", int'(enq_ready2), 0);
        chk(enq_ready1 == 1'b0, "R7", "slots1 ready with deq_ready", int'(enq_ready1), 0);
        drive(0, 8'h00, 1);
        // R9 a dequeue frees a slot in the next cycle
        chk(enq_ready2 == 1'b1, "R9", "slots2 freed", int'(enq_ready2), 1);
        chk(enq_ready1 == 1'b1, "R9", "slots1 freed", int'(enq_ready1), 1);
        drive(0, 8'h00, 1);
        // R5 rejected items absent; R9 empty dequeue no effect
        chk(deq_valid2 == 1'b0, "R5", "slots2 drained", int'(deq_valid2), 0);
        chk(deq_valid1 == 1'b0, "R5", "slots1 drained", int'(deq_valid1), 0);
        drive(0, 8'h00, 1);
        chk(deq_valid2 == 1'b0 && enq_ready2 == 1'b1, "R9", "slots2 empty pop", int'(deq_valid2), 0);
        chk(deq_valid1 == 1'b0 && enq_ready1 == 1'b1, "R9", "slots1 empty pop", int'(deq_valid1), 0);

        // Throughput from empty, both sides active for 20 cycles
        c2 = deq_cnt2;
        c1 = deq_cnt1;
        nxt = 8'h80;
        for (int k = 0; k < 20; k++) begin
            drive(1, nxt, 1);
            nxt = nxt + 8'd1;
        end
        drive(0, 8'h00, 0);
        #3;
        chk(deq_cnt2 - c2 == 19, "R6", "slots2 items in 20 cycles", deq_cnt2 - c2, 19);
        chk(deq_cnt1 - c1 == 10, "R7", "slots1 items in 20 cycles", deq_cnt1 - c1, 10);
        drive(0, 8'h00, 1);
        drive(0, 8'h00, 1);

        // Mixed pseudo-random traffic, R2 via scoreboard
        lfsr = 8'hA5;
        for (int k = 0; k < 80; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            drive(lfsr[0], nxt, lfsr[2] | lfsr[5]);
            nxt = nxt + 8'd1;
        end
        for (int k = 0; k < 4; k++) drive(0, 8'h00, 1);
        #3;
        chk(exp2.size() == 0, "R2", "slots2 items lost", exp2.size(), 0);
        chk(exp1.size() == 0, "R2", "slots1 items lost", exp1.size(), 0);

        // R4 no same-cycle offer; R6 crossing at occupancy one
        drive(1, 8'h5A, 0);
        chk(deq_valid2 == 1'b0, "R4", "slots2 not same cycle", int'(deq_valid2), 0);
        drive(1, 8'h5B, 1);
        chk(deq_valid2 == 1'b1 && enq_ready2 == 1'b1, "R6", "slots2 both sides open", int'(enq_ready2), 1);
        drive(0, 8'h00, 0);
        chk(deq_valid2 == 1'b1 && enq_ready2 == 1'b1, "R6", "slots2 still one item", int'(deq_valid2), 1);
        chk(deq_data2 == 8'h5B, "R6", "slots2 head after crossing", int'(deq_data2), 'h5B);
        chk(enq_ready1 == 1'b1 && deq_valid1 == 1'b0, "R7", "slots1 emptied", int'(deq_valid1), 0);
        drive(0, 8'h00, 1);
        drive(0, 8'h00, 1);

        // Reset with items inside
        drive(1, 8'h70, 0);
        drive(1, 8'h71, 0);
        @(negedge clk);
        rst = 1'b1;
        enq_valid = 1'b0;
        repeat (2) @(negedge clk);
        exp2.delete();
        exp1.delete();
        rst = 1'b0;
        drive(0, 8'h00, 0);
        chk(enq_ready2 == 1'b1 && deq_valid2 == 1'b0, "R1", "slots2 after reset", int'(deq_valid2), 0);
        chk(enq_ready1 == 1'b1 && deq_valid1 == 1'b0, "R1", "slots1 after reset", int'(deq_valid1), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule